// File: doc/BRIEF.md
# Presettable Pattern Address Sequencer

The sequencer produces an 11-bit address for a pattern memory. The low ten bits come from a counter, and the top bit is a bank select held in a control register. The counter advances on one tick source picked by a 2-bit selector. The choices are an accelerator tick, an on-board oscillator tick, or a manual clock that software drives by writing a rising edge into a control bit. Every source arrives as a one-cycle pulse in the system clock domain, and an external count-enable input gates all of them.

Two hardware paths reload the counter with a programmable preset value, and each has its own enable. One is an external sync pulse. The other is a match between the counter and a programmed terminal address, which makes the counter loop over a fixed window. A software clear bit forces the address to zero. A byte-wide register port holds the preset, the terminal address and the control byte, and it also returns the live address. Two monitor outputs show the selected tick and the hardware reload. The count-enable input must be tied high by the integrator when no gating source is present.

The counter is steered by a three-state machine registered from the control byte. S_ZERO is entered whenever the clear bit is set. S_STOP is entered when the clock selector is 00. S_RUN covers every other setting. Each state can go to any other state on the cycle after the control byte changes. The transitions are named T_CLEAR (to S_ZERO), T_HALT (to S_STOP) and T_START (to S_RUN). Ticks and terminal matches are acted on only in S_RUN. A sync reload is honoured in every state except while the clear bit is set.

Top module: `pattern_addr_seq`

## Requirements
- R1: The registers at index 33 (preset bits 7:0), 34 (preset bits 9:8 in bits 1:0), 35 (terminal bits 7:0), 36 (terminal bits 9:8 in bits 1:0) and 37 (control) keep all eight written bits and read them back. All of them reset to zero. Bits 7:2 of indexes 34 and 36 have no effect on counting. Indexes outside 33 to 39 read as zero.
- R2: While control bit 0 is set, pat_addr[9:0] reads zero from the cycle after the write. The counter is held at zero, ticks are ignored and mon_reload stays low. After the bit is cleared, counting resumes from zero.
- R3: With control bit 1 set, a sync_pulse loads the preset at the next clock edge, whether or not a tick is present. With control bit 1 clear, a sync_pulse has no effect.
- R4: With control bit 2 set and the clock selector running, a tick that arrives while the count equals the terminal address loads the preset in place of the increment.
- R5: Control bits 5:4 pick the tick source: 00 none, 01 accel_tick, 10 osc_tick, 11 manual clock. Ticks from an unselected source are ignored. When count_en is low, every source is ignored.
- R6: Each accepted tick adds one to the 10-bit count, and the count wraps from 1023 to 0.
- R7: With the manual source selected, a register write that takes control bit 7 from 0 to 1 adds exactly one to the count. A write that leaves bit 7 at 1 adds nothing.
- R8: Control bit 3 drives pat_addr[10]. Index 38 reads pat_addr[7:0]. Index 39 reads pat_addr[10:8] in bits 2:0, with zeros in bits 7:3.
- R9: When a sync reload and a terminal match fall in the same cycle, the counter takes the preset exactly once.
- R10: mon_tick is high in any cycle where the selected, gated source ticks. mon_reload is high in any cycle where a hardware reload (sync or terminal) is applied.
- R11: With preset 0x200, terminal 0x25C and control value 36 (oscillator source, terminal reload), the address steps through 0x200 to 0x25C and repeats with a period of 93 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 6 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_idx |
| accel_tick | input | 1 | Accelerator tick pulse |
| osc_tick | input | 1 | On-board oscillator tick pulse |
| count_en | input | 1 | Gate for all tick sources (tie high if unused) |
| sync_pulse | input | 1 | External sync reload request |
| pat_addr | output | 11 | Bank bit and counter value |
| mon_tick | output | 1 | Selected, gated tick monitor |
| mon_reload | output | 1 | Hardware reload monitor |

## Verification
A sync reload and a terminal-match reload can land on the same edge. An increment and a reload can also compete for that edge. The bench first steps the counter onto the terminal address. It then raises a tick and sync_pulse in the same cycle and expects the preset, not the preset plus one and not the terminal plus one. A second case holds the software clear while ticks arrive, and expects zero with mon_reload low. This shows that the clear outranks counting and never appears on the reload monitor.

// File: rtl/pas_pkg.sv
package pas_pkg;

    typedef enum logic [1:0] {
        S_ZERO = 2'd0,
        S_STOP = 2'd1,
        S_RUN  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'b00,
        SRC_ACCEL  = 2'b01,
        SRC_OSC    = 2'b10,
        SRC_MANUAL = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     man_clk;
        logic     spare;
        clk_src_e src;
        logic     bank;
        logic     term_en;
        logic     sync_en;
        logic     clr;
    } ctl_t;

endpackage

// File: rtl/pas_regs.sv
module pas_regs
    import pas_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int IDX_W    = 6,
    parameter int BASE_IDX = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] preset_o,
    output logic [CNT_W-1:0] term_o,
    output ctl_t             ctl_o,
    output logic             man_pulse_o,
    output logic [7:0]       rdata_o
);
    localparam int NREG    = 5;
    localparam int CTL_OFS = 4;

    logic [7:0]  byte_q [NREG];
    logic [15:0] preset_w;
    logic [15:0] term_w;
    logic        man_pulse_q;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    byte_q[g] <= '0;
                else if (wr_en && idx == IDX_W'(BASE_IDX + g))
                    byte_q[g] <= wdata;
            end
        end
    endgenerate

    // Rising edge of the manual clock bit, caught at the write itself.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            man_pulse_q <= 1'b0;
        else
            man_pulse_q <= wr_en && idx == IDX_W'(BASE_IDX + CTL_OFS)
                           && wdata[7] && !byte_q[CTL_OFS][7];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == IDX_W'(BASE_IDX + i))
                rdata_o = byte_q[i];
    end

    assign preset_w    = {byte_q[1], byte_q[0]};
    assign term_w      = {byte_q[3], byte_q[2]};
    assign preset_o    = preset_w[CNT_W-1:0];
    assign term_o      = term_w[CNT_W-1:0];
    assign ctl_o       = ctl_t'(byte_q[CTL_OFS]);
    assign man_pulse_o = man_pulse_q;

endmodule

// File: rtl/pas_tick_sel.sv
module pas_tick_sel
    import pas_pkg::*;
(
    input  clk_src_e src,
    input  logic     accel_tick,
    input  logic     osc_tick,
    input  logic     man_tick,
    input  logic     count_en,
    output logic     tick_o
);
    logic raw;

    always_comb begin
        unique case (src)
            SRC_OFF:    raw = 1'b0;
            SRC_ACCEL:  raw = accel_tick;
            SRC_OSC:    raw = osc_tick;
            SRC_MANUAL: raw = man_tick;
            default:    raw = 1'b0;
        endcase
    end

    assign tick_o = raw & count_en;

endmodule

// File: rtl/pas_core.sv
module pas_core
    import pas_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sync_en,
    input  logic             term_en,
    input  clk_src_e         src,
    input  logic             sync_pulse,
    input  logic             tick,
    input  logic [CNT_W-1:0] preset,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reload_o
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             do_sync, do_term, do_inc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_STOP;
        else
            state_q <= state_d;
    end

    // Transitions: T_CLEAR, T_HALT, T_START
    always_comb begin
        if (clr)
            state_d = S_ZERO;
        else if (src == SRC_OFF)
            state_d = S_STOP;
        else
            state_d = S_RUN;
    end

    // Per-state actions
    always_comb begin
        do_sync = 1'b0;
        do_term = 1'b0;
        do_inc  = 1'b0;
        unique case (state_q)
            S_ZERO: ;
            S_STOP: do_sync = sync_en & sync_pulse;
            S_RUN: begin
                do_sync = sync_en & sync_pulse;
                do_term = term_en & tick & (cnt_q == term);
                do_inc  = tick;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (do_sync || do_term)
            cnt_q <= preset;
        else if (do_inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign reload_o = (do_sync | do_term) & ~clr;

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0); // R2
    AST_SYNC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && sync_pulse && !clr && state_q != S_ZERO) |=> cnt_q == $past(preset)); // R3
    AST_TERM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && term_en && tick && cnt_q == term && !clr) |=> cnt_q == $past(preset)); // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && !(sync_en && sync_pulse) && !clr) |=> $stable(cnt_q)); // R5
    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && tick && !reload_o && !clr) |=> cnt_q == $past(cnt_q) + 1'b1); // R6

endmodule

// File: rtl/pattern_addr_seq.sv
module pattern_addr_seq
    import pas_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int IDX_W    = 6,
    parameter int BASE_IDX = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             accel_tick,
    input  logic             osc_tick,
    input  logic             count_en,
    input  logic             sync_pulse,
    output logic [CNT_W:0]   pat_addr,
    output logic             mon_tick,
    output logic             mon_reload
);
    localparam int ADDR_W = CNT_W + 1;
    localparam int IDX_LO = BASE_IDX + 5;
    localparam int IDX_HI = BASE_IDX + 6;

    logic [CNT_W-1:0] preset, term, cnt;
    ctl_t             ctl;
    logic             man_pulse, tick;
    logic [7:0]       cfg_rdata;
    logic [15:0]      addr_wide;

    pas_regs #(.CNT_W(CNT_W), .IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx),
        .wdata(reg_wdata), .preset_o(preset), .term_o(term), .ctl_o(ctl),
        .man_pulse_o(man_pulse), .rdata_o(cfg_rdata)
    );

    pas_tick_sel u_sel (
        .src(ctl.src), .accel_tick(accel_tick), .osc_tick(osc_tick),
        .man_tick(man_pulse), .count_en(count_en), .tick_o(tick)
    );

    pas_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .sync_en(ctl.sync_en),
        .term_en(ctl.term_en), .src(ctl.src), .sync_pulse(sync_pulse),
        .tick(tick), .preset(preset), .term(term), .cnt_o(cnt),
        .reload_o(mon_reload)
    );

    // Clear acts on the address at once, before the counter register follows.
    assign pat_addr  = {ctl.bank, ctl.clr ? {CNT_W{1'b0}} : cnt};
    assign mon_tick  = tick;
    assign addr_wide = 16'(pat_addr);

    always_comb begin
        if (reg_idx == IDX_W'(IDX_LO))
            reg_rdata = addr_wide[7:0];
        else if (reg_idx == IDX_W'(IDX_HI))
            reg_rdata = addr_wide[15:8];
        else
            reg_rdata = cfg_rdata;
    end

    AST_HI_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(IDX_HI)) |-> reg_rdata[7:ADDR_W-8] == '0); // R8
    AST_CLEAR_NO_MON: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr |-> !mon_reload); // R2

endmodule

// File: tb/pattern_addr_seq_bench.sv
module pattern_addr_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_idx = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       accel_tick = 1'b0, osc_tick = 1'b0, count_en = 1'b1, sync_pulse = 1'b0;
    logic [10:0] pat_addr;
    logic       mon_tick, mon_reload;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pattern_addr_seq u_pattern_addr_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .accel_tick(accel_tick),
        .osc_tick(osc_tick), .count_en(count_en), .sync_pulse(sync_pulse),
        .pat_addr(pat_addr), .mon_tick(mon_tick), .mon_reload(mon_reload)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [7:0] d);
        @(negedge clk); reg_idx = 6'(i); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input int i, output logic [7:0] d);
        reg_idx = 6'(i); #1; d = reg_rdata;
    endtask

    task automatic ticks(input int src, input int n);
        @(negedge clk);
        if (src == 0) accel_tick = 1'b1; else osc_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk); accel_tick = 1'b0; osc_tick = 1'b0;
    endtask

    task automatic sync_once(input logic exp_mon, input string req);
        @(negedge clk); sync_pulse = 1'b1; #1;
        check(req, 16'(mon_reload), 16'(exp_mon));
        @(posedge clk); @(negedge clk); sync_pulse = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 reset addr", 16'(pat_addr), 16'h0);
        for (int i = 33; i <= 39; i++) begin
            rd(i, d); check("R1 reset reg", 16'(d), 16'h0);
        end
        rd(12, d); check("R1 unmapped idx", 16'(d), 16'h0);
    endtask

    task automatic t_count;
        wr(37, 8'h10);
        @(negedge clk); accel_tick = 1'b1; #1;
        check("R10 mon_tick", 16'(mon_tick), 16'h1);
        accel_tick = 1'b0;
        check("R6 before ticks", 16'(pat_addr), 16'h0);
        ticks(0, 5); check("R6 five ticks", 16'(pat_addr), 16'h5);
        ticks(1, 3); check("R5 unselected osc", 16'(pat_addr), 16'h5);
        count_en = 1'b0;
        @(negedge clk); accel_tick = 1'b1; #1;
        check("R5 gated mon_tick", 16'(mon_tick), 16'h0);
        accel_tick = 1'b0;
        ticks(0, 3); check("R5 count_en low", 16'(pat_addr), 16'h5);
        count_en = 1'b1;
        wr(37, 8'h00);
        ticks(0, 2); check("R5 source off", 16'(pat_addr), 16'h5);
    endtask

    task automatic t_manual;
        wr(37, 8'h30);
        check("R7 select only", 16'(pat_addr), 16'h5);
        wr(37, 8'hB0); check("R7 rising edge", 16'(pat_addr), 16'h6);
        wr(37, 8'hB0); check("R7 no edge", 16'(pat_addr), 16'h6);
        wr(37, 8'h30);
        wr(37, 8'hB0); check("R7 second edge", 16'(pat_addr), 16'h7);
    endtask

    task automatic t_bank;
        logic [7:0] d;
        wr(37, 8'h08);
        check("R8 bank bit", 16'(pat_addr), 16'h407);
        rd(38, d); check("R8 low byte", 16'(d), 16'h07);
        rd(39, d); check("R8 high byte", 16'(d), 16'h04);
        rd(37, d); check("R1 ctl readback", 16'(d), 16'h08);
    endtask

    task automatic t_regs_sync;
        logic [7:0] d;
        wr(33, 8'hAB); wr(34, 8'hFD);
        rd(34, d); check("R1 upper bits stored", 16'(d), 16'hFD);
        wr(37, 8'h02);
        sync_once(1'b1, "R10 mon_reload sync");
        check("R1 upper bits ignored", 16'(pat_addr), 16'h1AB);
        wr(33, 8'h55); wr(34, 8'h01);
        sync_once(1'b1, "R3 sync mon");
        check("R3 sync load", 16'(pat_addr), 16'h155);
    endtask

    task automatic t_term;
        wr(35, 8'h58); wr(36, 8'h01);
        wr(37, 8'h14);
        ticks(0, 3); check("R4 reach terminal", 16'(pat_addr), 16'h158);
        @(negedge clk); accel_tick = 1'b1; #1;
        check("R10 mon_reload term", 16'(mon_reload), 16'h1);
        @(posedge clk); @(negedge clk); accel_tick = 1'b0;
        check("R4 terminal reload", 16'(pat_addr), 16'h155);
        ticks(0, 2);
        wr(37, 8'h10);
        sync_once(1'b0, "R3 disabled mon");
        check("R3 sync disabled", 16'(pat_addr), 16'h157);
    endtask

    task automatic t_coincide;
        wr(37, 8'h16);
        ticks(0, 1); check("R9 at terminal", 16'(pat_addr), 16'h158);
        @(negedge clk); accel_tick = 1'b1; sync_pulse = 1'b1;
        @(posedge clk); @(negedge clk); accel_tick = 1'b0; sync_pulse = 1'b0;
        check("R9 single preset load", 16'(pat_addr), 16'h155);
    endtask

    task automatic t_wrap;
        wr(33, 8'hFE); wr(34, 8'h03);
        wr(37, 8'h12);
        sync_once(1'b1, "R6 wrap preload mon");
        check("R6 preload", 16'(pat_addr), 16'h3FE);
        ticks(0, 3); check("R6 wrap", 16'(pat_addr), 16'h001);
    endtask

    task automatic t_clear;
        wr(37, 8'h11);
        check("R2 zero at once", 16'(pat_addr), 16'h0);
        @(negedge clk); accel_tick = 1'b1; #1;
        check("R2 no reload mon", 16'(mon_reload), 16'h0);
        @(posedge clk); @(posedge clk); @(negedge clk); accel_tick = 1'b0;
        check("R2 held", 16'(pat_addr), 16'h0);
        wr(37, 8'h10);
        check("R2 released", 16'(pat_addr), 16'h0);
        ticks(0, 1); check("R2 resume", 16'(pat_addr), 16'h1);
    endtask

    task automatic t_check_case;
        wr(33, 8'h00); wr(34, 8'h02); wr(35, 8'h5C); wr(36, 8'h02);
        wr(37, 8'h02);
        sync_once(1'b1, "R11 preload mon");
        wr(37, 8'd36);
        check("R11 start", 16'(pat_addr), 16'h200);
        ticks(1, 92); check("R11 terminal", 16'(pat_addr), 16'h25C);
        ticks(1, 1);  check("R11 period 93", 16'(pat_addr), 16'h200);
        ticks(1, 107); check("R11 200 ticks", 16'(pat_addr), 16'h20E);
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_manual();
        t_bank();
        t_regs_sync();
        t_term();
        t_coincide();
        t_wrap();
        t_clear();
        t_check_case();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule